// File: doc/BRIEF.md
# Paired Register Memory Access Unit

This unit executes a small family of custom instructions, each of which moves two general registers to or from memory. It receives a 32-bit instruction word with a valid strobe, the value of the base register and, for stores, the values of the two data registers. In the same cycle it decides whether the word is a legal paired access. A legal word is accepted and its two effective addresses are latched. The unit then performs two accesses in order over a simple single-port memory request interface.

Loads come in three forms: a doubleword pair, a sign-extending word pair and a zero-extending word pair. Both loaded values are kept in internal holding registers. The two register write-backs are presented together, and only after both reads have completed without error. A failed access ends the sequence with a fault indication and the failing address, and no register is written. A mode input selects 64-bit or 32-bit operation. Doubleword forms are rejected in 32-bit mode.

Top module: `pairmem_unit`

## Requirements
- R1: A word is accepted only when all of the following hold: bits 6:0 equal 0001011; bits 14:12 equal 100 (load) or 101 (store); and bits 31:27 equal 11111 (doubleword pair, load or store), 11100 (word pair: a sign-extending load or a store) or 11110 (zero-extending word load, loads only). Any other word raises `illegal` in the cycle it is presented.
- R2: The first data register is in bits 11:7, the base register in bits 19:15, the second data register in bits 24:20 and the offset field in bits 26:25. A word is illegal if the base register equals either data register, or if the two data registers are equal.
- R3: Doubleword forms are illegal while `rv64_mode` is 0. Word forms are legal in both modes.
- R4: `illegal` is combinational on `insn_valid` while the unit is idle. An illegal word issues no memory request and leaves the unit idle.
- R5: The first address is base + (offset << 4) for doubleword forms and base + (offset << 3) for word forms. The second address is the first plus 8 (doubleword) or plus 4 (word). `mem_size` is 1 for doubleword accesses and 0 for word accesses.
- R6: The access to the first address is issued before the access to the second. A store writes `st_data1` to the first address and then `st_data2` to the second, with `mem_we` = 1. Word stores use `mem_wdata[31:0]`. A store produces no write-back.
- R7: A word load takes `mem_rdata[31:0]`. The sign-extending form copies bit 31 into the upper bits of the result, and the zero-extending form clears them. A doubleword load returns all 64 bits.
- R8: `wb_valid` pulses for one cycle, in the cycle after the second read completes without error. It carries both data values and both destination register numbers. An error on either access suppresses the write-back, skips any remaining access, and reports `fault` with `fault_addr` equal to the failing address.
- R9: `done` pulses for one cycle at the end of every accepted instruction. `busy` is high from the cycle after acceptance until the cycle after `done`. A word presented while busy is ignored and does not raise `illegal`.
- R10: `mem_req` and `mem_addr` stay unchanged while `mem_ready` is low. Each access completes in the cycle `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rv64_mode | input | 1 | 1 selects 64-bit mode; 0 selects 32-bit mode |
| insn_valid | input | 1 | Instruction word is presented |
| insn | input | 32 | Instruction word |
| base_val | input | XLEN | Value of the base register |
| st_data1 | input | XLEN | Value of the first data register (stores) |
| st_data2 | input | XLEN | Value of the second data register (stores) |
| illegal | output | 1 | Presented word rejected (same cycle) |
| busy | output | 1 | A sequence is in progress |
| mem_req | output | 1 | Memory request |
| mem_addr | output | XLEN | Request byte address |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_size | output | 1 | 1 for a doubleword access, 0 for a word access |
| mem_wdata | output | XLEN | Write data |
| mem_ready | input | 1 | Current request completes this cycle |
| mem_rdata | input | XLEN | Read data, valid with mem_ready |
| mem_err | input | 1 | Current access failed, valid with mem_ready |
| wb_valid | output | 1 | Both load results are ready for write-back |
| wb_rd1 | output | 5 | First destination register |
| wb_data1 | output | XLEN | First loaded value |
| wb_rd2 | output | 5 | Second destination register |
| wb_data2 | output | XLEN | Second loaded value |
| done | output | 1 | Sequence finished |
| fault | output | 1 | Sequence ended on a memory error (with done) |
| fault_addr | output | XLEN | Address of the failing access |

## Verification
The assertions check, on every cycle, the properties that hold independently of data. A rejected word is never followed by a request. A stalled request holds its address. The second address follows the first by the access stride. An error never leads to a write-back. `wb_valid` never appears for a store, and `done` always returns the unit to idle. Only the bench scenarios can show the data-dependent behaviour: the exact encodings that are accepted, the offset scaling for each size, the sign and zero extension of loaded words, the store data placement, and the fact that memory contents are untouched after a failed first store access.

// File: rtl/pairmem_pkg.sv
package pairmem_pkg;

   localparam logic [6:0] PAIR_OPCODE = 7'b0001011;
   localparam logic [2:0] F3_LOAD     = 3'b100;
   localparam logic [2:0] F3_STORE    = 3'b101;
   localparam logic [4:0] SEL_DWORD   = 5'b11111;
   localparam logic [4:0] SEL_WORD    = 5'b11100;
   localparam logic [4:0] SEL_UWORD   = 5'b11110;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ACC1,
      ST_ACC2,
      ST_WB,
      ST_DONE
   } seq_state_t;

   typedef struct packed {
      logic       is_store;
      logic       dword;
      logic       uns;
      logic [4:0] rd1;
      logic [4:0] rd2;
   } pair_op_t;

endpackage

// File: rtl/pairmem_decode.sv
module pairmem_decode
   import pairmem_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [31:0]     insn,
   input  logic            rv64_mode,
   input  logic [XLEN-1:0] base_val,
   output logic            legal,
   output pair_op_t        op,
   output logic [XLEN-1:0] addr1,
   output logic [XLEN-1:0] addr2
);

   logic [6:0] opc;
   logic [2:0] f3;
   logic [4:0] sel, f_rd1, f_rs, f_rd2;
   logic [1:0] sh2;
   logic       is_ld, is_st, sel_d, sel_w, sel_u;
   logic       enc_ok, dword_allowed, mode_ok, overlap;
   logic [XLEN-1:0] offset, stride;

   assign opc   = insn[6:0];
   assign f_rd1 = insn[11:7];
   assign f3    = insn[14:12];
   assign f_rs  = insn[19:15];
   assign f_rd2 = insn[24:20];
   assign sh2   = insn[26:25];
   assign sel   = insn[31:27];

   assign is_ld = (f3 == F3_LOAD);
   assign is_st = (f3 == F3_STORE);
   assign sel_d = (sel == SEL_DWORD);
   assign sel_w = (sel == SEL_WORD);
   assign sel_u = (sel == SEL_UWORD);

   // Doubleword forms exist only in a 64-bit datapath; the mode input gates them there.
   generate
      if (XLEN == 64) begin : g_rv64
         assign dword_allowed = rv64_mode;
      end else if (XLEN == 32) begin : g_rv32
         assign dword_allowed = 1'b0;
      end else begin : g_bad_xlen
         $error("pairmem_decode: XLEN must be 32 or 64");
      end
   endgenerate

   assign enc_ok  = (opc == PAIR_OPCODE) &&
                    ((is_ld && (sel_d || sel_w || sel_u)) || (is_st && (sel_d || sel_w)));
   assign mode_ok = !sel_d || dword_allowed;
   assign overlap = (f_rs == f_rd1) || (f_rs == f_rd2) || (f_rd1 == f_rd2);
   assign legal   = enc_ok && mode_ok && !overlap;

   assign offset = sel_d ? XLEN'({sh2, 4'b0000}) : XLEN'({sh2, 3'b000});
   assign stride = sel_d ? XLEN'(8) : XLEN'(4);
   assign addr1  = base_val + offset;
   assign addr2  = addr1 + stride;

   assign op.is_store = is_st;
   assign op.dword    = sel_d;
   assign op.uns      = sel_u;
   assign op.rd1      = f_rd1;
   assign op.rd2      = f_rd2;

endmodule

// File: rtl/pairmem_extend.sv
module pairmem_extend #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] raw,
   input  logic            dword,
   input  logic            uns,
   output logic [XLEN-1:0] ext
);

   localparam int WORD_W = 32;
   localparam int PAD_W  = XLEN - WORD_W;

   generate
      if (XLEN > WORD_W) begin : g_wide
         logic [PAD_W-1:0] pad;
         assign pad = uns ? '0 : {PAD_W{raw[WORD_W-1]}};
         assign ext = dword ? raw : {pad, raw[WORD_W-1:0]};
      end else begin : g_narrow
         logic unused_sel;
         assign unused_sel = dword ^ uns;
         assign ext = raw;
      end
   endgenerate

endmodule

// File: rtl/pairmem_seq.sv
module pairmem_seq
   import pairmem_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  pair_op_t        op,
   input  logic [XLEN-1:0] addr1,
   input  logic [XLEN-1:0] addr2,
   input  logic [XLEN-1:0] st_data1,
   input  logic [XLEN-1:0] st_data2,
   output logic            busy,
   output logic            mem_req,
   output logic [XLEN-1:0] mem_addr,
   output logic            mem_we,
   output logic            mem_size,
   output logic [XLEN-1:0] mem_wdata,
   input  logic            mem_ready,
   input  logic [XLEN-1:0] mem_rdata,
   input  logic            mem_err,
   output logic            wb_valid,
   output logic [4:0]      wb_rd1,
   output logic [XLEN-1:0] wb_data1,
   output logic [4:0]      wb_rd2,
   output logic [XLEN-1:0] wb_data2,
   output logic            done,
   output logic            fault,
   output logic [XLEN-1:0] fault_addr
);

   seq_state_t      state;
   pair_op_t        op_q;
   logic [XLEN-1:0] a1_q, a2_q, sd1_q, sd2_q, tmp1_q, tmp2_q, faddr_q;
   logic            fault_q;
   logic [XLEN-1:0] rd_ext;

   pairmem_extend #(.XLEN(XLEN)) u_extend (
      .raw   (mem_rdata),
      .dword (op_q.dword),
      .uns   (op_q.uns),
      .ext   (rd_ext)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= '0;
         a1_q    <= '0;
         a2_q    <= '0;
         sd1_q   <= '0;
         sd2_q   <= '0;
         tmp1_q  <= '0;
         tmp2_q  <= '0;
         faddr_q <= '0;
         fault_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               op_q    <= op;
               a1_q    <= addr1;
               a2_q    <= addr2;
               sd1_q   <= st_data1;
               sd2_q   <= st_data2;
               fault_q <= 1'b0;
               state   <= ST_ACC1;
            end
            ST_ACC1: if (mem_ready) begin
               if (mem_err) begin
                  fault_q <= 1'b1;
                  faddr_q <= a1_q;
                  state   <= ST_DONE;
               end else begin
                  tmp1_q <= rd_ext;
                  state  <= ST_ACC2;
               end
            end
            ST_ACC2: if (mem_ready) begin
               if (mem_err) begin
                  fault_q <= 1'b1;
                  faddr_q <= a2_q;
                  state   <= ST_DONE;
               end else begin
                  tmp2_q <= rd_ext;
                  state  <= op_q.is_store ? ST_DONE : ST_WB;
               end
            end
            ST_WB:   state <= ST_DONE;
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state != ST_IDLE);
   assign mem_req    = (state == ST_ACC1) || (state == ST_ACC2);
   assign mem_addr   = (state == ST_ACC2) ? a2_q : a1_q;
   assign mem_wdata  = (state == ST_ACC2) ? sd2_q : sd1_q;
   assign mem_we     = op_q.is_store;
   assign mem_size   = op_q.dword;
   assign wb_valid   = (state == ST_WB);
   assign wb_rd1     = op_q.rd1;
   assign wb_rd2     = op_q.rd2;
   assign wb_data1   = tmp1_q;
   assign wb_data2   = tmp2_q;
   assign done       = (state == ST_DONE);
   assign fault      = done && fault_q;
   assign fault_addr = faddr_q;

   p_second_addr_stride_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACC1 && mem_ready && !mem_err) |=>
         (mem_addr == $past(mem_addr) + (op_q.dword ? XLEN'(8) : XLEN'(4))));

   p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   p_err_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready && mem_err) |=> (done && fault && !wb_valid));

   p_store_no_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> !mem_we);

   p_done_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   p_single_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wb_valid, done, mem_req}));

endmodule

// File: rtl/pairmem_unit.sv
module pairmem_unit
   import pairmem_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rv64_mode,
   input  logic            insn_valid,
   input  logic [31:0]     insn,
   input  logic [XLEN-1:0] base_val,
   input  logic [XLEN-1:0] st_data1,
   input  logic [XLEN-1:0] st_data2,
   output logic            illegal,
   output logic            busy,
   output logic            mem_req,
   output logic [XLEN-1:0] mem_addr,
   output logic            mem_we,
   output logic            mem_size,
   output logic [XLEN-1:0] mem_wdata,
   input  logic            mem_ready,
   input  logic [XLEN-1:0] mem_rdata,
   input  logic            mem_err,
   output logic            wb_valid,
   output logic [4:0]      wb_rd1,
   output logic [XLEN-1:0] wb_data1,
   output logic [4:0]      wb_rd2,
   output logic [XLEN-1:0] wb_data2,
   output logic            done,
   output logic            fault,
   output logic [XLEN-1:0] fault_addr
);

   logic            legal, start;
   pair_op_t        dec_op;
   logic [XLEN-1:0] dec_a1, dec_a2;

   pairmem_decode #(.XLEN(XLEN)) u_decode (
      .insn      (insn),
      .rv64_mode (rv64_mode),
      .base_val  (base_val),
      .legal     (legal),
      .op        (dec_op),
      .addr1     (dec_a1),
      .addr2     (dec_a2)
   );

   assign start   = insn_valid && !busy && legal;
   assign illegal = insn_valid && !busy && !legal;

   pairmem_seq #(.XLEN(XLEN)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .op         (dec_op),
      .addr1      (dec_a1),
      .addr2      (dec_a2),
      .st_data1   (st_data1),
      .st_data2   (st_data2),
      .busy       (busy),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_we     (mem_we),
      .mem_size   (mem_size),
      .mem_wdata  (mem_wdata),
      .mem_ready  (mem_ready),
      .mem_rdata  (mem_rdata),
      .mem_err    (mem_err),
      .wb_valid   (wb_valid),
      .wb_rd1     (wb_rd1),
      .wb_data1   (wb_data1),
      .wb_rd2     (wb_rd2),
      .wb_data2   (wb_data2),
      .done       (done),
      .fault      (fault),
      .fault_addr (fault_addr)
   );

   p_illegal_no_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> (!mem_req && !busy));

   p_accept_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && !busy && !illegal) |=> (busy && mem_req));

   p_busy_no_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !illegal);

endmodule

// File: tb/pairmem_unit_bench.sv
module pairmem_unit_bench;

   localparam int XLEN = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            rv64_mode = 1'b1;
   logic            insn_valid = 1'b0;
   logic [31:0]     insn = '0;
   logic [XLEN-1:0] base_val = '0, st_data1 = '0, st_data2 = '0;
   logic            illegal, busy, mem_req, mem_we, mem_size;
   logic [XLEN-1:0] mem_addr, mem_wdata, mem_rdata;
   logic            mem_ready, mem_err;
   logic            wb_valid, done, fault;
   logic [4:0]      wb_rd1, wb_rd2;
   logic [XLEN-1:0] wb_data1, wb_data2, fault_addr;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   pairmem_unit #(.XLEN(XLEN)) u_pairmem_unit (
      .clk(clk), .rst_n(rst_n), .rv64_mode(rv64_mode), .insn_valid(insn_valid),
      .insn(insn), .base_val(base_val), .st_data1(st_data1), .st_data2(st_data2),
      .illegal(illegal), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_size(mem_size), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err),
      .wb_valid(wb_valid), .wb_rd1(wb_rd1), .wb_data1(wb_data1), .wb_rd2(wb_rd2),
      .wb_data2(wb_data2), .done(done), .fault(fault), .fault_addr(fault_addr)
   );

   // ---------------- memory model ----------------
   logic [63:0] mem [0:31];
   int          wait_cyc = 0;
   int          wcnt = 0;
   logic        err_en = 1'b0;
   logic [63:0] err_addr = '0;
   logic [63:0] cur_word;

   function automatic logic [63:0] pat(input int i);
      return {32'h1234_5600 + i, 32'h8765_4300 + i};
   endfunction

   assign cur_word  = mem[mem_addr[7:3]];
   assign mem_ready = mem_req && (wcnt >= wait_cyc);
   assign mem_err   = err_en && (mem_addr == err_addr);
   assign mem_rdata = mem_size ? cur_word :
                      {32'hDEAD_BEEF, (mem_addr[2] ? cur_word[63:32] : cur_word[31:0])};

   always @(posedge clk) begin
      if (!rst_n || !mem_req || mem_ready) wcnt <= 0;
      else wcnt <= wcnt + 1;
      if (mem_req && mem_ready && mem_we && !mem_err) begin
         if (mem_size) mem[mem_addr[7:3]] <= mem_wdata;
         else if (mem_addr[2]) mem[mem_addr[7:3]][63:32] <= mem_wdata[31:0];
         else mem[mem_addr[7:3]][31:0] <= mem_wdata[31:0];
      end
   end

   // ---------------- helpers ----------------
   function automatic logic [31:0] enc(input logic [4:0] sel, input logic [1:0] sh,
                                       input logic [4:0] r2, input logic [4:0] rs,
                                       input logic [2:0] f3, input logic [4:0] r1,
                                       input logic [6:0] opc = 7'b0001011);
      return {sel, sh, r2, rs, f3, r1, opc};
   endfunction

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   int          n_acc, n_wb;
   logic [63:0] acc_addr [0:3];
   logic [63:0] acc_wd   [0:3];
   logic        acc_we   [0:3];
   logic        acc_sz   [0:3];
   logic [63:0] got_d1, got_d2;
   logic [4:0]  got_r1, got_r2;
   logic        got_fault, ill_busy;
   logic [63:0] got_faddr;

   task automatic run_op(input logic [31:0] w, input logic [63:0] base,
                         input logic [63:0] d1, input logic [63:0] d2,
                         input logic rv64, input logic hold, input logic exp_ill,
                         input string tag);
      n_acc = 0; n_wb = 0; got_fault = 1'b0; ill_busy = 1'b0;
      got_d1 = '0; got_d2 = '0; got_r1 = '0; got_r2 = '0; got_faddr = '0;
      @(negedge clk);
      insn = w; base_val = base; st_data1 = d1; st_data2 = d2;
      rv64_mode = rv64; insn_valid = 1'b1;
      #1;
      chk({tag, " illegal flag"}, 64'(illegal), 64'(exp_ill));
      if (exp_ill) begin
         @(negedge clk);
         insn_valid = 1'b0;
         for (int k = 0; k < 3; k++) begin
            chk({tag, " R4 no request after illegal"}, 64'(mem_req), 64'd0);
            chk({tag, " R4 stays idle"}, 64'(busy), 64'd0);
            @(negedge clk);
         end
         return;
      end
      for (int cyc = 0; cyc < 200; cyc++) begin
         @(negedge clk);
         if (!hold) insn_valid = 1'b0;
         if (illegal) ill_busy = 1'b1;
         if (mem_req && mem_ready) begin
            if (n_acc < 4) begin
               acc_addr[n_acc] = mem_addr; acc_wd[n_acc] = mem_wdata;
               acc_we[n_acc] = mem_we; acc_sz[n_acc] = mem_size;
            end
            n_acc++;
         end
         if (wb_valid) begin
            n_wb++; got_d1 = wb_data1; got_d2 = wb_data2; got_r1 = wb_rd1; got_r2 = wb_rd2;
         end
         if (done) begin
            got_fault = fault; got_faddr = fault_addr;
            insn_valid = 1'b0;
            break;
         end
      end
      @(negedge clk);
      chk({tag, " R9 idle after done"}, 64'(busy), 64'd0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R9 reset busy", 64'(busy), 64'd0);
      chk("R10 reset mem_req", 64'(mem_req), 64'd0);
      chk("R8 reset wb_valid", 64'(wb_valid), 64'd0);
      chk("R4 reset illegal", 64'(illegal), 64'd0);
   endtask

   task automatic t_ldd();
      wait_cyc = 1;
      run_op(enc(5'b11111, 2'd1, 5'd6, 5'd7, 3'b100, 5'd5), 64'h40, 0, 0, 1'b1, 1'b0, 1'b0, "ldd");
      chk("R5 ldd access count", 64'(n_acc), 64'd2);
      chk("R5 ldd addr1", acc_addr[0], 64'h50);
      chk("R5 ldd addr2", acc_addr[1], 64'h58);
      chk("R5 ldd size", 64'(acc_sz[0]), 64'd1);
      chk("R7 ldd data1", got_d1, pat(10));
      chk("R7 ldd data2", got_d2, pat(11));
      chk("R2 ldd rd1", 64'(got_r1), 64'd5);
      chk("R2 ldd rd2", 64'(got_r2), 64'd6);
      chk("R8 ldd one write-back", 64'(n_wb), 64'd1);
      chk("R8 ldd no fault", 64'(got_fault), 64'd0);
      wait_cyc = 0;
   endtask

   task automatic t_lwd();
      run_op(enc(5'b11100, 2'd3, 5'd9, 5'd2, 3'b100, 5'd8), 64'h20, 0, 0, 1'b1, 1'b0, 1'b0, "lwd");
      chk("R5 lwd addr1", acc_addr[0], 64'h38);
      chk("R5 lwd addr2", acc_addr[1], 64'h3C);
      chk("R5 lwd size", 64'(acc_sz[1]), 64'd0);
      chk("R7 lwd sign-extended", got_d1, 64'hFFFF_FFFF_8765_4307);
      chk("R7 lwd positive word", got_d2, 64'h0000_0000_1234_5607);
   endtask

   task automatic t_lwud();
      run_op(enc(5'b11110, 2'd3, 5'd9, 5'd2, 3'b100, 5'd8), 64'h20, 0, 0, 1'b1, 1'b0, 1'b0, "lwud");
      chk("R7 lwud zero-extended", got_d1, 64'h0000_0000_8765_4307);
      chk("R7 lwud second", got_d2, 64'h0000_0000_1234_5607);
   endtask

   task automatic t_sdd();
      wait_cyc = 2;
      run_op(enc(5'b11111, 2'd2, 5'd11, 5'd12, 3'b101, 5'd10), 64'h80,
             64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b1, 1'b0, 1'b0, "sdd");
      chk("R10 sdd no repeated access under wait states", 64'(n_acc), 64'd2);
      chk("R6 sdd first addr", acc_addr[0], 64'hA0);
      chk("R6 sdd second addr", acc_addr[1], 64'hA8);
      chk("R6 sdd write enable", 64'(acc_we[0] & acc_we[1]), 64'd1);
      chk("R6 sdd data order 1", acc_wd[0], 64'h1111_2222_3333_4444);
      chk("R6 sdd data order 2", acc_wd[1], 64'h5555_6666_7777_8888);
      chk("R6 sdd memory 1", mem[20], 64'h1111_2222_3333_4444);
      chk("R6 sdd memory 2", mem[21], 64'h5555_6666_7777_8888);
      chk("R6 sdd no write-back", 64'(n_wb), 64'd0);
      wait_cyc = 0;
   endtask

   task automatic t_swd();
      run_op(enc(5'b11100, 2'd0, 5'd3, 5'd4, 3'b101, 5'd1), 64'h10,
             64'hAAAA_AAAA_0BAD_F00D, 64'hBBBB_BBBB_C0DE_CAFE, 1'b1, 1'b0, 1'b0, "swd");
      chk("R5 swd addr1", acc_addr[0], 64'h10);
      chk("R5 swd addr2", acc_addr[1], 64'h14);
      chk("R6 swd word data", acc_wd[0][31:0], 64'h0BAD_F00D);
      chk("R6 swd memory", mem[2], 64'hC0DE_CAFE_0BAD_F00D);
   endtask

   task automatic t_overlap();
      run_op(enc(5'b11111, 2'd0, 5'd6, 5'd5, 3'b100, 5'd5), 64'h40, 0, 0, 1'b1, 1'b0, 1'b1, "R2 base==rd1");
      run_op(enc(5'b11100, 2'd0, 5'd7, 5'd7, 3'b101, 5'd5), 64'h40, 0, 0, 1'b1, 1'b0, 1'b1, "R2 base==rd2");
      run_op(enc(5'b11110, 2'd0, 5'd5, 5'd7, 3'b100, 5'd5), 64'h40, 0, 0, 1'b1, 1'b0, 1'b1, "R2 rd1==rd2");
   endtask

   task automatic t_mode();
      run_op(enc(5'b11111, 2'd0, 5'd6, 5'd7, 3'b100, 5'd5), 64'h40, 0, 0, 1'b0, 1'b0, 1'b1, "R3 ldd in 32-bit mode");
      run_op(enc(5'b11111, 2'd0, 5'd6, 5'd7, 3'b101, 5'd5), 64'h40, 0, 0, 1'b0, 1'b0, 1'b1, "R3 sdd in 32-bit mode");
      run_op(enc(5'b11100, 2'd0, 5'd6, 5'd7, 3'b100, 5'd5), 64'h00, 0, 0, 1'b0, 1'b0, 1'b0, "R3 lwd in 32-bit mode");
      chk("R3 lwd runs in 32-bit mode", 64'(n_acc), 64'd2);
      chk("R3 lwd data in 32-bit mode", got_d1, 64'hFFFF_FFFF_8765_4300);
   endtask

   task automatic t_encoding();
      run_op(enc(5'b11111, 2'd0, 5'd6, 5'd7, 3'b100, 5'd5, 7'b0001111), 64'h40, 0, 0, 1'b1, 1'b0, 1'b1, "R1 wrong opcode");
      run_op(enc(5'b11110, 2'd0, 5'd6, 5'd7, 3'b101, 5'd5), 64'h40, 0, 0, 1'b1, 1'b0, 1'b1, "R1 unsigned store");
      run_op(enc(5'b11100, 2'd0, 5'd6, 5'd7, 3'b110, 5'd5), 64'h40, 0, 0, 1'b1, 1'b0, 1'b1, "R1 bad funct3");
      run_op(enc(5'b10101, 2'd0, 5'd6, 5'd7, 3'b100, 5'd5), 64'h40, 0, 0, 1'b1, 1'b0, 1'b1, "R1 bad selector");
   endtask

   task automatic t_fault_load();
      err_en = 1'b1; err_addr = 64'h58;
      run_op(enc(5'b11111, 2'd1, 5'd6, 5'd7, 3'b100, 5'd5), 64'h40, 0, 0, 1'b1, 1'b0, 1'b0, "ldd fault");
      chk("R8 no write-back on second fault", 64'(n_wb), 64'd0);
      chk("R8 fault flag", 64'(got_fault), 64'd1);
      chk("R8 fault address", got_faddr, 64'h58);
      err_en = 1'b0;
   endtask

   task automatic t_fault_store();
      err_en = 1'b1; err_addr = 64'hC0;
      run_op(enc(5'b11111, 2'd0, 5'd6, 5'd7, 3'b101, 5'd5), 64'hC0,
             64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_0000_FFFF, 1'b1, 1'b0, 1'b0, "sdd fault");
      chk("R8 second access skipped", 64'(n_acc), 64'd1);
      chk("R8 store fault address", got_faddr, 64'hC0);
      chk("R8 memory 1 untouched", mem[24], pat(24));
      chk("R8 memory 2 untouched", mem[25], pat(25));
      err_en = 1'b0;
   endtask

   task automatic t_busy_ignore();
      run_op(enc(5'b11111, 2'd0, 5'd6, 5'd7, 3'b100, 5'd5), 64'h00, 0, 0, 1'b1, 1'b1, 1'b0, "busy hold");
      chk("R9 held word not re-accepted", 64'(n_acc), 64'd2);
      chk("R9 single write-back", 64'(n_wb), 64'd1);
      chk("R9 no illegal while busy", 64'(ill_busy), 64'd0);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mem[i] = pat(i);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_ldd();
      t_lwd();
      t_lwud();
      t_sdd();
      t_swd();
      t_overlap();
      t_mode();
      t_encoding();
      t_fault_load();
      t_fault_store();
      t_busy_ignore();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule